// File: doc/BRIEF.md
# Sequential Page Prefetch Predictor

This block sits beside an accelerator's address translator and observes the virtual page number of every translated access. When the accelerator walks through pages in strictly ascending order, one page at a time, the block infers a streaming pattern. It then names the pages just ahead of the current one, so that system software can load them into local memory before the accelerator asks for them. Each page is named once, as a single-cycle pulse.

The block also judges its own guesses. Every named page stays in a small tracking table until the accelerator touches it or software evicts it. A predicted page that is touched without a miss raises a saturating confidence counter. A predicted page that is evicted untouched, or is touched but still misses, lowers it. When confidence reaches zero the block raises a bail-out flag and names no further pages until confidence recovers.

Top module: `seqpf_predictor`

## Requirements
- R1: After reset is released, `pred_valid` is low and `bail` is low. Confidence starts at 2 on a scale of 0 to 3.
- R2: A new-page event is a valid access whose page differs from the previous accessed page. The stream locks after three consecutive new-page events whose page is exactly one above the previous page. An access that repeats the previous page neither counts toward the lock nor breaks it.
- R3: Once locked, with `last` the most recent page, the block emits the pages last+1 through last+DEPTH (DEPTH defaults to 2) in ascending order, one per cycle. The first page appears on the clock edge after the edge that sampled the locking access.
- R4: A page is never emitted twice within one locked run. When the accelerator advances by one page, only the single newly uncovered page is emitted.
- R5: An access with `acc_miss` low to an outstanding predicted page raises confidence by one, saturating at 3. Evicting an outstanding page that was never touched lowers it by one. So does an access with `acc_miss` high to an outstanding page. Evicting a page that is not outstanding has no effect.
- R6: `bail` is high exactly while confidence is 0, and no page is emitted while `bail` is high.
- R7: A confidence rise and a confidence fall caused in the same cycle cancel each other.
- R8: A new-page event with any stride other than +1 drops the lock and discards all outstanding predictions without changing confidence. Emission resumes only after a fresh lock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| acc_valid | input | 1 | An accelerator access is presented this cycle |
| acc_vpn | input | VPN_W | Virtual page number of the access |
| acc_miss | input | 1 | The access missed in local memory |
| evict_valid | input | 1 | Software evicts a page this cycle |
| evict_vpn | input | VPN_W | Virtual page number being evicted |
| pred_valid | output | 1 | One-cycle pulse: `pred_vpn` names a page to load ahead |
| pred_vpn | output | VPN_W | Predicted page number |
| bail | output | 1 | Predictions withdrawn because confidence is zero |

## Verification
In one cycle, a hit on one outstanding prediction can coincide with the eviction of another, unused one. Confidence then receives an increment and a decrement at the same edge. The bench provokes this by driving the access and the eviction together, and judges the net result at the ports. It counts how many further untouched evictions are needed before `bail` rises. Exactly two must be needed, which shows the counter held its starting level rather than moving either way.

// File: rtl/seqpf_pkg.sv
package seqpf_pkg;
  // Saturating add/subtract step for a small confidence counter.
  function automatic int sat_step(int cur, int up, int dn, int top);
    int n;
    n = cur + up - dn;
    if (n < 0) n = 0;
    if (n > top) n = top;
    return n;
  endfunction
endpackage

// File: rtl/seqpf_stride_det.sv
module seqpf_stride_det #(
  parameter int VPN_W   = 20,
  parameter int CONFIRM = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             acc_valid,
  input  logic [VPN_W-1:0] acc_vpn,
  output logic [VPN_W-1:0] last_vpn,
  output logic             locked,
  output logic             broke
);
  localparam int SW = $clog2(CONFIRM + 1);

  logic [VPN_W-1:0] last_q, last_d;
  logic             seen_q, seen_d;
  logic [SW-1:0]    run_q, run_d;
  logic             new_ev, step1;

  assign new_ev = acc_valid && (!seen_q || (acc_vpn != last_q));
  assign step1  = seen_q && (acc_vpn == last_q + 1'b1);

  always_comb begin
    last_d = last_q;
    seen_d = seen_q;
    run_d  = run_q;
    if (new_ev) begin
      last_d = acc_vpn;
      seen_d = 1'b1;
      if (step1) run_d = (run_q == SW'(CONFIRM)) ? run_q : run_q + 1'b1;
      else       run_d = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      last_q <= '0;
      seen_q <= 1'b0;
      run_q  <= '0;
    end else if (new_ev) begin
      last_q <= last_d;
      seen_q <= seen_d;
      run_q  <= run_d;
    end
  end

  assign last_vpn = last_q;
  assign locked   = (run_q == SW'(CONFIRM));
  assign broke    = new_ev && !step1;
endmodule

// File: rtl/seqpf_pred_table.sv
module seqpf_pred_table #(
  parameter int VPN_W = 20,
  parameter int DEPTH = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             flush,
  input  logic             alloc_en,
  input  logic [VPN_W-1:0] alloc_vpn,
  input  logic             acc_valid,
  input  logic [VPN_W-1:0] acc_vpn,
  input  logic             acc_miss,
  input  logic             ev_valid,
  input  logic [VPN_W-1:0] ev_vpn,
  output logic             has_free,
  output logic             used,
  output logic [1:0]       waste
);
  logic [DEPTH-1:0] slot_v;
  logic [VPN_W-1:0] slot_vpn [DEPTH];
  logic [DEPTH-1:0] hit_acc, hit_ev, free_oh;

  always_comb begin
    free_oh = '0;
    for (int i = DEPTH - 1; i >= 0; i--) begin
      if (!slot_v[i]) begin
        free_oh    = '0;
        free_oh[i] = 1'b1;
      end
    end
  end

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    logic v_d, alloc;
    assign hit_acc[g] = slot_v[g] && acc_valid && (slot_vpn[g] == acc_vpn);
    assign hit_ev[g]  = slot_v[g] && ev_valid && (slot_vpn[g] == ev_vpn) && !hit_acc[g];
    assign alloc      = alloc_en && free_oh[g];

    always_comb begin
      v_d = slot_v[g];
      if (flush)                        v_d = 1'b0;
      else if (alloc)                   v_d = 1'b1;
      else if (hit_acc[g] || hit_ev[g]) v_d = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        slot_v[g]   <= 1'b0;
        slot_vpn[g] <= '0;
      end else begin
        slot_v[g] <= v_d;
        if (alloc) slot_vpn[g] <= alloc_vpn;
      end
    end
  end

  assign has_free = |(~slot_v);
  assign used     = (|hit_acc) && !acc_miss;
  assign waste    = {1'b0, (|hit_acc) && acc_miss} + {1'b0, |hit_ev};
endmodule

// File: rtl/seqpf_conf.sv
module seqpf_conf #(
  parameter int CONF_W    = 2,
  parameter int CONF_INIT = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       up,
  input  logic [1:0] down,
  output logic       bail
);
  localparam int CONF_MAX = (1 << CONF_W) - 1;

  logic [CONF_W-1:0] conf_q, conf_d;
  logic              conf_en;

  assign conf_en = up || (down != 2'd0);
  assign conf_d  = CONF_W'(seqpf_pkg::sat_step(int'(conf_q), int'(up), int'(down), CONF_MAX));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       conf_q <= CONF_W'(CONF_INIT);
    else if (conf_en) conf_q <= conf_d;
  end

  assign bail = (conf_q == '0);
endmodule

// File: rtl/seqpf_predictor.sv
module seqpf_predictor #(
  parameter int VPN_W     = 20,
  parameter int DEPTH     = 2,
  parameter int CONFIRM   = 3,
  parameter int CONF_W    = 2,
  parameter int CONF_INIT = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             acc_valid,
  input  logic [VPN_W-1:0] acc_vpn,
  input  logic             acc_miss,
  input  logic             evict_valid,
  input  logic [VPN_W-1:0] evict_vpn,
  output logic             pred_valid,
  output logic [VPN_W-1:0] pred_vpn,
  output logic             bail
);
  localparam int XW = VPN_W + 1;

  logic             rst_meta_n, rst_q_n;
  logic [VPN_W-1:0] det_last;
  logic             det_locked, det_broke;
  logic             tab_free, tab_used;
  logic [1:0]       tab_waste;
  logic [VPN_W-1:0] head_q, head_d, eff;
  logic             emit;
  logic             pv_q;
  logic [VPN_W-1:0] pvpn_q;

  // Reset: asserted asynchronously, released on the clock.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_n <= 1'b0;
      rst_q_n    <= 1'b0;
    end else begin
      rst_meta_n <= 1'b1;
      rst_q_n    <= rst_meta_n;
    end
  end

  seqpf_stride_det #(.VPN_W(VPN_W), .CONFIRM(CONFIRM)) u_det (
    .clk(clk), .rst_n(rst_q_n), .acc_valid(acc_valid), .acc_vpn(acc_vpn),
    .last_vpn(det_last), .locked(det_locked), .broke(det_broke)
  );

  seqpf_pred_table #(.VPN_W(VPN_W), .DEPTH(DEPTH)) u_tab (
    .clk(clk), .rst_n(rst_q_n), .flush(det_broke),
    .alloc_en(emit), .alloc_vpn(eff),
    .acc_valid(acc_valid), .acc_vpn(acc_vpn), .acc_miss(acc_miss),
    .ev_valid(evict_valid), .ev_vpn(evict_vpn),
    .has_free(tab_free), .used(tab_used), .waste(tab_waste)
  );

  seqpf_conf #(.CONF_W(CONF_W), .CONF_INIT(CONF_INIT)) u_conf (
    .clk(clk), .rst_n(rst_q_n), .up(tab_used), .down(tab_waste), .bail(bail)
  );

  // Next page to name: never behind the current page, never repeated.
  assign eff = (head_q > det_last) ? head_q : det_last + 1'b1;

  always_comb begin
    emit = det_locked && !bail && tab_free && !det_broke
        && ({1'b0, eff} <= ({1'b0, det_last} + XW'(DEPTH)))
        && !(acc_valid && (acc_vpn == eff));
    head_d = head_q;
    if (!det_locked) head_d = '0;
    else if (emit)   head_d = eff + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      head_q <= '0;
      pv_q   <= 1'b0;
      pvpn_q <= '0;
    end else if (!rst_q_n) begin
      head_q <= '0;
      pv_q   <= 1'b0;
      pvpn_q <= '0;
    end else begin
      head_q <= head_d;
      pv_q   <= emit;
      if (emit) pvpn_q <= eff;
    end
  end

  assign pred_valid = pv_q;
  assign pred_vpn   = pvpn_q;
endmodule

// File: rtl/seqpf_predictor_chk.sv
module seqpf_predictor_chk #(
  parameter int VPN_W = 20,
  parameter int DEPTH = 2
) (
  input logic             clk,
  input logic             rst_n,
  input logic             pred_valid,
  input logic [VPN_W-1:0] pred_vpn,
  input logic             bail,
  input logic             locked,
  input logic [VPN_W-1:0] last_vpn,
  input logic [1:0]       waste
);
  // R3: a named page lies strictly ahead of the last page, within DEPTH
  a_r3_window: assert property (@(posedge clk) disable iff (!rst_n)
    pred_valid |-> (({1'b0, pred_vpn} > {1'b0, $past(last_vpn)}) &&
                    ({1'b0, pred_vpn} <= {1'b0, $past(last_vpn)} + (VPN_W+1)'(DEPTH))));

  // R4: back-to-back pulses name consecutive pages
  a_r4_ascend: assert property (@(posedge clk) disable iff (!rst_n)
    (pred_valid && $past(pred_valid)) |-> (pred_vpn == $past(pred_vpn) + 1'b1));

  // R2: nothing is named without a confirmed stream
  a_r2_needs_lock: assert property (@(posedge clk) disable iff (!rst_n)
    pred_valid |-> $past(locked));

  // R6: bail-out suppresses the following emission
  a_r6_bail_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    bail |=> !pred_valid);

  // R5: bail-out only rises after a wasted prediction
  a_r5_bail_cause: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bail) |-> ($past(waste) != 2'd0));
endmodule

bind seqpf_predictor seqpf_predictor_chk #(.VPN_W(VPN_W), .DEPTH(DEPTH)) u_chk (
  .clk(clk), .rst_n(rst_q_n), .pred_valid(pred_valid), .pred_vpn(pred_vpn),
  .bail(bail), .locked(det_locked), .last_vpn(det_last), .waste(tab_waste)
);

// File: tb/seqpf_predictor_bench.sv
`timescale 1ns/1ps
module seqpf_predictor_bench;
  localparam int VW = 20;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          acc_valid = 1'b0, acc_miss = 1'b0, evict_valid = 1'b0;
  logic [VW-1:0] acc_vpn = '0, evict_vpn = '0;
  logic          pred_valid, bail;
  logic [VW-1:0] pred_vpn;

  int n_run = 0, n_fail = 0, pcount = 0;
  int plog [128];
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  seqpf_predictor #(.VPN_W(VW)) u_seqpf_predictor (
    .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_vpn(acc_vpn),
    .acc_miss(acc_miss), .evict_valid(evict_valid), .evict_vpn(evict_vpn),
    .pred_valid(pred_valid), .pred_vpn(pred_vpn), .bail(bail)
  );

  // Record every prediction pulse.
  always @(negedge clk) begin
    if (rst_n && pred_valid) begin
      plog[pcount % 128] = int'(pred_vpn);
      pcount++;
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0; acc_valid = 1'b0; acc_miss = 1'b0; evict_valid = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic touch(input int v, input bit miss);
    acc_valid = 1'b1; acc_vpn = VW'(v); acc_miss = miss;
    @(negedge clk);
    acc_valid = 1'b0; acc_miss = 1'b0;
    repeat (6) @(negedge clk);
  endtask

  task automatic drop(input int v);
    evict_valid = 1'b1; evict_vpn = VW'(v);
    @(negedge clk);
    evict_valid = 1'b0;
    repeat (6) @(negedge clk);
  endtask

  // Checks the pulses logged since base: n pages starting at first.
  task automatic expect_preds(input int base, input int n, input int first, input string req);
    check(pcount - base == n, req, pcount - base, n);
    for (int i = 0; i < n && i < pcount - base; i++)
      check(plog[(base + i) % 128] == first + i, req, plog[(base + i) % 128], first + i);
  endtask

  task automatic lock_at10();
    touch(10, 1'b1); touch(11, 1'b1); touch(12, 1'b1); touch(13, 1'b1);
  endtask

  task automatic t_reset();
    do_reset();
    check(pred_valid == 1'b0, "R1 pred_valid", int'(pred_valid), 0);
    check(bail == 1'b0, "R1 bail", int'(bail), 0);
  endtask

  task automatic t_lock();
    int base;
    do_reset();
    base = pcount;
    touch(10, 1'b1); touch(11, 1'b1); touch(12, 1'b1);
    check(pcount == base, "R2 no early lock", pcount - base, 0);
    touch(13, 1'b1);
    expect_preds(base, 2, 14, "R3 first window");
  endtask

  task automatic t_repeat();
    int base;
    do_reset();
    base = pcount;
    touch(10, 1'b1); touch(11, 1'b1); touch(11, 1'b0); touch(12, 1'b1);
    check(pcount == base, "R2 repeat not counted", pcount - base, 0);
    touch(13, 1'b1);
    expect_preds(base, 2, 14, "R2 repeat keeps streak");
  endtask

  task automatic t_break();
    int base;
    do_reset();
    lock_at10();
    base = pcount;
    touch(40, 1'b1); touch(41, 1'b1); touch(42, 1'b1);
    check(pcount == base, "R8 lock dropped", pcount - base, 0);
    touch(43, 1'b1);
    expect_preds(base, 2, 44, "R8 relock");
    check(bail == 1'b0, "R8 flush keeps confidence", int'(bail), 0);
  endtask

  task automatic t_slide();
    int base;
    do_reset();
    lock_at10();
    base = pcount;
    touch(14, 1'b0);
    expect_preds(base, 1, 16, "R4 slide one page");
  endtask

  task automatic t_bail();
    int base;
    do_reset();
    lock_at10();
    drop(99);
    check(bail == 1'b0, "R5 foreign evict ignored", int'(bail), 0);
    drop(14);
    check(bail == 1'b0, "R5 one waste", int'(bail), 0);
    drop(15);
    check(bail == 1'b1, "R6 bail at zero", int'(bail), 1);
    base = pcount;
    touch(14, 1'b1);
    check(pcount == base, "R6 no emission in bail", pcount - base, 0);
    check(bail == 1'b1, "R6 bail held", int'(bail), 1);
  endtask

  task automatic t_miss();
    int base;
    do_reset();
    lock_at10();
    base = pcount;
    touch(14, 1'b1);
    expect_preds(base, 1, 16, "R5 miss on predicted page");
    check(bail == 1'b0, "R5 miss lowers by one", int'(bail), 0);
    drop(15);
    check(bail == 1'b1, "R5 miss counted as waste", int'(bail), 1);
  endtask

  task automatic t_cancel();
    int base;
    do_reset();
    lock_at10();
    base = pcount;
    acc_valid = 1'b1; acc_vpn = VW'(14); acc_miss = 1'b0;
    evict_valid = 1'b1; evict_vpn = VW'(15);
    @(negedge clk);
    acc_valid = 1'b0; evict_valid = 1'b0;
    repeat (6) @(negedge clk);
    expect_preds(base, 1, 16, "R7 window after joint event");
    drop(16);
    check(bail == 1'b0, "R7 net zero (not fallen)", int'(bail), 0);
    base = pcount;
    touch(15, 1'b0);
    expect_preds(base, 1, 17, "R7 next page");
    drop(17);
    check(bail == 1'b1, "R7 net zero (not risen)", int'(bail), 1);
  endtask

  task automatic t_sat();
    int base;
    do_reset();
    lock_at10();
    base = pcount;
    touch(14, 1'b0); touch(15, 1'b0);
    expect_preds(base, 2, 16, "R5 hits slide window");
    drop(16); drop(17);
    check(bail == 1'b0, "R5 saturated at three", int'(bail), 0);
    base = pcount;
    touch(16, 1'b0);
    expect_preds(base, 1, 18, "R5 next page");
    drop(18);
    check(bail == 1'b1, "R5 saturation limit", int'(bail), 1);
  endtask

  initial begin
    t_reset();
    t_lock();
    t_repeat();
    t_break();
    t_slide();
    t_bail();
    t_miss();
    t_cancel();
    t_sat();
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule